// File: doc/BRIEF.md
# Bus Start/Stop Condition Sequencer

This block forms START and STOP conditions on a two-wire open-drain bus for the master side of a controller. It does not toggle the clock line itself. Instead it issues single-cycle requests to a separate clock generator to lower or raise SCL. It follows the real SCL level through the rising, falling and delayed-falling pulses that an edge detector supplies, and it drives SDA only through a pull-low enable. Two pulses from a separate condition detector tell it when any START or STOP shows up on the bus.

A condition is built in up to four ordered steps:

1. Lower SCL, when SDA has to change and SCL is high.
2. Move SDA to the level opposite the wanted transition.
3. Raise SCL.
4. Make the SDA transition while SCL is high.

A step that the present line levels already satisfy is skipped. Every step that does run is followed by a hold of `HOLD_CYCLES` system clocks. When the final hold ends, the block pulses a done output. If another device's condition appears before the block reaches its final step, it drops the sequence and pulses an early-condition output.

Top module: `cond_sequencer`

## Requirements
- R1: During and right after a synchronous active-high reset, `sda_pull_o`, `scl_low_req_o`, `scl_high_req_o`, `done_o` and `early_o` are 0, and SCL is assumed to be high.
- R2: A START requested with SCL high and SDA released issues no SCL requests. It sets `sda_pull_o` to 1 (1 = pull SDA low) and completes.
- R3: A STOP requested while the block holds SDA low and SCL is high issues no SCL requests. It only clears `sda_pull_o`.
- R4: `scl_low_req_o` pulses for one cycle only when SCL is high and SDA differs from the level required before the edge. After such a request, `sda_pull_o` does not change until `scl_fall_dly_i` has been seen. Outside the final step, `sda_pull_o` changes only while SCL is low.
- R5: When SCL is low before the final step, `scl_high_req_o` pulses once for one cycle. The final SDA change waits for `scl_rise_i`. The two SCL requests are never high together.
- R6: Each executed step is followed by a hold of `HOLD_CYCLES` clocks. `done_o` rises exactly `HOLD_CYCLES` cycles after the final change of `sda_pull_o`.
- R7: When `done_o` is high, `sda_pull_o` is 1 after a START and 0 after a STOP. SCL is left high.
- R8: When `req_start_i` and `req_stop_i` are high in the same idle cycle, a START is produced.
- R9: A detected START or STOP arriving before the final step pulses `early_o` for one cycle. In that case `done_o` is not raised and `sda_pull_o` is left unchanged. The block then returns to idle and accepts a new request.
- R10: Detected conditions while idle, or during the final step and its hold, do not raise `early_o`.
- R11: `done_o` and `early_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_start_i | input | 1 | Request a START (wins over a STOP request) |
| req_stop_i | input | 1 | Request a STOP |
| sda_i | input | 1 | Sampled SDA level |
| scl_rise_i | input | 1 | One-cycle pulse on an observed SCL rising edge |
| scl_fall_i | input | 1 | One-cycle pulse on an observed SCL falling edge |
| scl_fall_dly_i | input | 1 | Delayed SCL falling pulse; SDA may change after it |
| bus_start_i | input | 1 | START seen on the bus by the detector |
| bus_stop_i | input | 1 | STOP seen on the bus by the detector |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| scl_low_req_o | output | 1 | One-cycle request to drive SCL low |
| scl_high_req_o | output | 1 | One-cycle request to release SCL high |
| done_o | output | 1 | Requested condition completed |
| early_o | output | 1 | Foreign condition seen before own condition |

## Verification
The assertions guard properties that must hold on every cycle:
- SDA never moves while SCL is high except in the final step.
- The SCL requests and the done and early pulses are exclusive, one-cycle events.
- At completion, the SDA drive matches the requested condition.
- An abort leaves the SDA drive as it was.

Only the bench's scenarios can show the rest: which steps are skipped for each starting combination of line levels, the exact hold before done, start priority, and recovery after an early abort. It shows these with a bus model that answers the SCL requests and reports the block's own conditions back through the detector inputs.

// File: rtl/cond_seq_pkg.sv
package cond_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_LOW   = 4'd1,
    ST_WFALL = 4'd2,
    ST_PRE   = 4'd3,
    ST_HIGH  = 4'd4,
    ST_WRISE = 4'd5,
    ST_EDGE  = 4'd6,
    ST_WAIT  = 4'd7,
    ST_FIN   = 4'd8
  } cs_state_e;

endpackage

// File: rtl/cond_scl_level.sv
module cond_scl_level (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic fall_i,
  output logic scl_hi_o
);

  always_ff @(posedge clk) begin
    if (rst)         scl_hi_o <= 1'b1;
    else if (fall_i) scl_hi_o <= 1'b0;
    else if (rise_i) scl_hi_o <= 1'b1;
  end

endmodule

// File: rtl/cond_hold_timer.sv
module cond_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic zero_o
);

  localparam int unsigned CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= RELOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);

endmodule

// File: rtl/cond_sequencer.sv
module cond_sequencer
  import cond_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_start_i,
  input  logic req_stop_i,
  input  logic sda_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic scl_fall_dly_i,
  input  logic bus_start_i,
  input  logic bus_stop_i,
  output logic sda_pull_o,
  output logic scl_low_req_o,
  output logic scl_high_req_o,
  output logic done_o,
  output logic early_o
);

  cs_state_e st, st_d, nxt, nxt_d;
  logic      tgt_start, tgt_start_d;   // 1: START in progress (pre-edge SDA level high)
  logic      pull_d, lo_d, hi_d, done_d, early_d;
  logic      tmr_load, tmr_zero, scl_hi;
  logic      abortable, foreign_cond;

  cond_scl_level u_level (
    .clk      (clk),
    .rst      (rst),
    .rise_i   (scl_rise_i),
    .fall_i   (scl_fall_i),
    .scl_hi_o (scl_hi)
  );

  cond_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .zero_o (tmr_zero)
  );

  // Own final edge (and its hold) is not treated as a foreign condition.
  assign abortable    = (st != ST_IDLE) && (st != ST_EDGE) &&
                        !((st == ST_WAIT) && (nxt == ST_FIN));
  assign foreign_cond = bus_start_i || bus_stop_i;

  always_comb begin
    st_d        = st;
    nxt_d       = nxt;
    tgt_start_d = tgt_start;
    pull_d      = sda_pull_o;
    lo_d        = 1'b0;
    hi_d        = 1'b0;
    done_d      = 1'b0;
    early_d     = 1'b0;
    tmr_load    = 1'b0;
    if (abortable && foreign_cond) begin
      early_d = 1'b1;
      st_d    = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req_start_i) begin
            tgt_start_d = 1'b1;
            st_d        = ST_LOW;
          end else if (req_stop_i) begin
            tgt_start_d = 1'b0;
            st_d        = ST_LOW;
          end
        end
        ST_LOW: begin
          if (scl_hi && (sda_i != tgt_start)) begin
            lo_d = 1'b1;
            st_d = ST_WFALL;
          end else begin
            st_d = ST_PRE;
          end
        end
        ST_WFALL: begin
          if (scl_fall_dly_i) begin
            tmr_load = 1'b1;
            nxt_d    = ST_PRE;
            st_d     = ST_WAIT;
          end
        end
        ST_PRE: begin
          if (sda_i == tgt_start) begin
            st_d = ST_HIGH;
          end else if (scl_hi) begin
            st_d = ST_LOW;
          end else begin
            pull_d   = !tgt_start;
            tmr_load = 1'b1;
            nxt_d    = ST_HIGH;
            st_d     = ST_WAIT;
          end
        end
        ST_HIGH: begin
          if (!scl_hi) begin
            hi_d = 1'b1;
            st_d = ST_WRISE;
          end else begin
            st_d = ST_EDGE;
          end
        end
        ST_WRISE: begin
          if (scl_rise_i) begin
            tmr_load = 1'b1;
            nxt_d    = ST_EDGE;
            st_d     = ST_WAIT;
          end
        end
        ST_EDGE: begin
          pull_d   = tgt_start;
          tmr_load = 1'b1;
          nxt_d    = ST_FIN;
          st_d     = ST_WAIT;
        end
        ST_WAIT: begin
          if (tmr_zero) begin
            if (nxt == ST_FIN) begin
              done_d = 1'b1;
              st_d   = ST_IDLE;
            end else begin
              st_d = nxt;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      nxt            <= ST_IDLE;
      tgt_start      <= 1'b0;
      sda_pull_o     <= 1'b0;
      scl_low_req_o  <= 1'b0;
      scl_high_req_o <= 1'b0;
      done_o         <= 1'b0;
      early_o        <= 1'b0;
    end else begin
      st             <= st_d;
      nxt            <= nxt_d;
      tgt_start      <= tgt_start_d;
      sda_pull_o     <= pull_d;
      scl_low_req_o  <= lo_d;
      scl_high_req_o <= hi_d;
      done_o         <= done_d;
      early_o        <= early_d;
    end
  end

  // R4
  sda_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_o != $past(sda_pull_o)) |-> (!$past(scl_hi) || ($past(st) == ST_EDGE)));

  // R4
  low_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scl_low_req_o |=> !scl_low_req_o);

  // R5
  high_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scl_high_req_o |=> !scl_high_req_o);

  // R5
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(scl_low_req_o && scl_high_req_o));

  // R7
  done_level_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (sda_pull_o == tgt_start));

  // R9
  early_hold_chk: assert property (@(posedge clk) disable iff (rst)
    early_o |-> (sda_pull_o == $past(sda_pull_o)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11
  end_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && early_o));

endmodule

// File: tb/cond_sequencer_bench.sv
module cond_sequencer_bench;

  localparam int unsigned HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start_i = 1'b0, req_stop_i = 1'b0;
  logic sda_i;
  logic scl_rise_i = 1'b0, scl_fall_i = 1'b0, scl_fall_dly_i = 1'b0;
  logic bus_start_i = 1'b0, bus_stop_i = 1'b0;
  logic sda_pull_o, scl_low_req_o, scl_high_req_o, done_o, early_o;

  always #4 clk = ~clk;   // 125 MHz

  assign sda_i = ~sda_pull_o;

  cond_sequencer #(.HOLD_CYCLES(HOLD)) u_cond_sequencer (
    .clk            (clk),
    .rst            (rst),
    .req_start_i    (req_start_i),
    .req_stop_i     (req_stop_i),
    .sda_i          (sda_i),
    .scl_rise_i     (scl_rise_i),
    .scl_fall_i     (scl_fall_i),
    .scl_fall_dly_i (scl_fall_dly_i),
    .bus_start_i    (bus_start_i),
    .bus_stop_i     (bus_stop_i),
    .sda_pull_o     (sda_pull_o),
    .scl_low_req_o  (scl_low_req_o),
    .scl_high_req_o (scl_high_req_o),
    .done_o         (done_o),
    .early_o        (early_o)
  );

  int n_vec = 0, n_bad = 0;
  int n_fall = 0, n_rise = 0, n_done = 0, n_early = 0, lat = -1;
  int ext_fall_cnt = 0, ext_det_cnt = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bus model: answers SCL requests and reports own conditions via the detector inputs.
  initial begin
    bit scl_lvl = 1'b1;
    bit pull_prev = 1'b0;
    int since = 0;
    int fall_t = 0;
    int ext_fall_seen = 0, ext_det_seen = 0;
    forever begin
      @(negedge clk);
      scl_fall_i = 0; scl_rise_i = 0; scl_fall_dly_i = 0;
      bus_start_i = 0; bus_stop_i = 0;
      if (sda_pull_o != pull_prev) begin
        since = 0;
        if (scl_lvl) begin
          if (sda_pull_o) bus_start_i = 1; else bus_stop_i = 1;
        end
        pull_prev = sda_pull_o;
      end else begin
        since++;
      end
      if (done_o) begin n_done++; lat = since; end
      if (early_o) n_early++;
      if (scl_low_req_o) begin
        n_fall++; scl_lvl = 0; scl_fall_i = 1; fall_t = 2;
      end else if (fall_t == 2) begin
        fall_t = 1;
      end else if (fall_t == 1) begin
        scl_fall_dly_i = 1; fall_t = 0;
      end
      if (scl_high_req_o) begin n_rise++; scl_lvl = 1; scl_rise_i = 1; end
      if (ext_fall_cnt != ext_fall_seen) begin
        ext_fall_seen = ext_fall_cnt; scl_lvl = 0; scl_fall_i = 1;
      end
      if (ext_det_cnt != ext_det_seen) begin
        ext_det_seen = ext_det_cnt; bus_start_i = 1;
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic wait_end(input int e0, input int d0);
    for (int k = 0; k < 300; k++) begin
      if (n_done != d0 || n_early != e0) break;
      step();
    end
    repeat (3) step();
  endtask

  // {prelow, start, stop, falls[1:0], rises[1:0], final pull}
  localparam int NV = 11;
  localparam logic [7:0] VEC [NV] = '{
    8'b0_1_0_00_00_1,  // START from idle bus
    8'b0_0_1_00_00_0,  // STOP after held START
    8'b0_0_1_01_01_0,  // STOP from released idle bus
    8'b0_1_0_00_00_1,  // START
    8'b0_1_0_01_01_1,  // repeated START
    8'b0_0_1_00_00_0,  // STOP
    8'b0_1_1_00_00_1,  // both requested, START wins
    8'b0_0_1_00_00_0,  // STOP
    8'b1_0_1_00_01_0,  // STOP with SCL already low
    8'b1_1_0_00_01_1,  // START with SCL already low
    8'b0_0_1_00_00_0   // STOP
  };

  initial begin
    repeat (4) step();
    // R1: reset state
    chk("R1 sda_pull_o in reset", int'(sda_pull_o), 0);
    rst = 1'b0;
    step();
    chk("R1 sda_pull_o", int'(sda_pull_o), 0);
    chk("R1 scl_low_req_o", int'(scl_low_req_o), 0);
    chk("R1 scl_high_req_o", int'(scl_high_req_o), 0);
    chk("R1 done_o", int'(done_o), 0);
    chk("R1 early_o", int'(early_o), 0);

    for (int i = 0; i < NV; i++) begin
      int f0, r0, d0, e0;
      logic [7:0] v;
      v = VEC[i];
      if (v[7]) begin
        ext_fall_cnt++;
        repeat (3) step();
      end
      f0 = n_fall; r0 = n_rise; d0 = n_done; e0 = n_early;
      req_start_i = v[6]; req_stop_i = v[5];
      step();
      req_start_i = 0; req_stop_i = 0;
      wait_end(e0, d0);
      chk("R4 SCL low requests", n_fall - f0, int'(v[4:3]));
      chk("R5 SCL high requests", n_rise - r0, int'(v[2:1]));
      chk("R7 final sda_pull_o", int'(sda_pull_o), int'(v[0]));
      chk("R11 done pulses", n_done - d0, 1);
      chk("R10 no early on own condition", n_early - e0, 0);
      chk("R6 done latency after last SDA change", lat, HOLD);
      if (i == 0) chk("R2 no SCL activity on idle START", (n_fall - f0) + (n_rise - r0), 0);
      if (i == 1) chk("R3 STOP releases only", (n_fall - f0) + (n_rise - r0), 0);
      if (i == 6) chk("R8 start priority", int'(sda_pull_o), 1);
    end

    // R10: detected condition while idle is ignored
    begin
      int e0 = n_early;
      ext_det_cnt++;
      repeat (5) step();
      chk("R10 idle condition ignored", n_early - e0, 0);
    end

    // R9: foreign condition during SCL lowering aborts
    begin
      int f0, d0, e0, r0;
      f0 = n_fall; d0 = n_done; e0 = n_early;
      req_stop_i = 1;
      step();
      req_stop_i = 0;
      for (int k = 0; k < 50 && n_fall == f0; k++) step();
      ext_det_cnt++;
      wait_end(e0, d0);
      chk("R9 early pulse", n_early - e0, 1);
      chk("R9 no done on abort", n_done - d0, 0);
      chk("R9 SDA drive unchanged", int'(sda_pull_o), 0);
      // recovery: SCL now low, new STOP runs
      r0 = n_rise; d0 = n_done; e0 = n_early; f0 = n_fall;
      req_stop_i = 1;
      step();
      req_stop_i = 0;
      wait_end(e0, d0);
      chk("R9 recovery done", n_done - d0, 1);
      chk("R9 recovery SCL low requests", n_fall - f0, 0);
      chk("R9 recovery SCL high requests", n_rise - r0, 1);
      chk("R9 recovery final SDA", int'(sda_pull_o), 0);
      chk("R6 recovery done latency", lat, HOLD);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule